// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Transmit Status Flags

This block turns bytes into asynchronous serial frames on a single output line. A byte written into the holding register waits there until the shifter is free. At the next baud tick it moves into the shift register and goes out as a frame. The frame is a low start bit, eight data bits with the least significant bit first, an optional multiprocessor bit, and a high stop bit. The holding register is double-buffered against the shifter, so software or DMA can queue the next byte while the current one is still being sent.

Two status flags report progress. The data-empty flag says the holding register may be refilled. The end flag says the line has gone quiet with nothing left to send. Software uses a small register bus with separate read and write strobes, and a DMA engine can load the holding register through its own write port. Software clears the data-empty flag with a protected sequence: it must first read the status register while the flag is set, and then write zero to the flag's bit. The multiprocessor bit is not buffered. The control bit is used live, at the moment its slot in the frame begins.

Top module: `async_tx_flags`

Register map (2-bit address): 0 = control (bit 0 transmit on, bit 1 multiprocessor format); 1 = holding data (8 bits); 2 = status (bit 0 multiprocessor bit value, read/write; bit 1 end flag, read only; bit 2 data-empty flag); 3 reads zero. The read data shows the addressed register at all times. The read strobe only matters for arming the clear sequence.

## Requirements
- R1: After reset the line is 1, the status register reads 0x06 (data-empty 1, end 1, multiprocessor bit 0) and the control register reads 0.
- R2: With transmit on and the data-empty flag 0, the frame begins on the first baud tick. The line goes 0 for one tick period, then carries the 8 data bits LSB first, one tick period each, then a 1 stop bit for one tick period.
- R3: With the multiprocessor format on, one extra slot sits between the last data bit and the stop bit. It carries the value of status bit 0 as it stands when the slot begins, so a write made earlier in the same frame changes the bit sent.
- R4: With the multiprocessor format off, no extra slot is sent and status bit 0 has no effect on the line.
- R5: The data-empty flag goes to 1 on the tick where the holding register moves into the shift register.
- R6: A status write with bit 2 = 0 clears both the data-empty flag and the end flag, but only if a status read happened while data-empty was 1 and no status write or DMA write came between them. A write without that read leaves both flags unchanged.
- R7: A DMA write loads the holding register and clears the data-empty flag and the end flag.
- R8: At the tick that ends a stop bit, the end flag goes to 1 if data-empty is 1. If data-empty is 0, the next frame's start bit begins on that same tick with no idle gap.
- R9: While transmit is off, the end flag reads 1, the line is 1, and any frame in progress is dropped.
- R10: Bus writes to status bit 1, and writes of 1 to status bit 2, never change the flags.
- R11: The line rests at 1 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse marking each bit period |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (arms the flag clear) |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Contents of the addressed register |
| dmaWrEn | input | 1 | DMA write strobe to the holding register |
| dmaWrData | input | 8 | DMA write data |
| txLine | output | 1 | Serial output line |

## Verification
The hardest state to reach is the join between two frames: a stop bit ends while the holding register already contains new data, so the end flag must stay low and the next start bit must follow with no gap. The stimulus reaches it by polling the status register until data-empty rises mid-frame and then issuing a DMA write at once. A second hard case is a change to the multiprocessor bit partway through a frame. The bench times that write a few ticks after the start bit, so it lands before the slot opens. A cycle-accurate behavioural model checks the line and the read data on every clock.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int DATA_ADDR = 1;
  localparam int STAT_ADDR = 2;

  localparam int STAT_MPB_BIT  = 0;
  localparam int STAT_END_BIT  = 1;
  localparam int STAT_TDRE_BIT = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_MPB   = 3'd3,
    ST_STOP  = 3'd4
  } txState_e;

  typedef struct packed {
    logic emitStart;
    logic emitData;
    logic emitMpb;
    logic emitStop;
    logic forceIdle;
  } txStrobe_t;

endpackage

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        wrBits,
  input  logic              dmaWrEn,
  output txStrobe_t         stb,
  output logic              tdre,
  output logic              tend,
  output logic              mpbt,
  output logic              txOn,
  output logic              mpMode
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic ctrlWr, stWr, stRd, swClear;
  logic armed, loadEvt, endEvt;
  txState_e state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  assign ctrlWr  = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign stWr    = wrEn && (addr == ADDR_W'(STAT_ADDR));
  assign stRd    = rdEn && (addr == ADDR_W'(STAT_ADDR));
  assign swClear = stWr && !wrBits[STAT_TDRE_BIT] && armed;

  // frame sequencing
  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    stb        = '0;
    loadEvt    = 1'b0;
    endEvt     = 1'b0;
    if (!txOn) begin
      stateNext     = ST_IDLE;
      bitCntNext    = '0;
      stb.forceIdle = 1'b1;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          if (!tdre) begin
            stateNext     = ST_START;
            stb.emitStart = 1'b1;
            loadEvt       = 1'b1;
          end
        end
        ST_START: begin
          stateNext    = ST_DATA;
          bitCntNext   = '0;
          stb.emitData = 1'b1;
        end
        ST_DATA: begin
          if (bitCnt == LAST_BIT) begin
            if (mpMode) begin
              stateNext   = ST_MPB;
              stb.emitMpb = 1'b1;
            end else begin
              stateNext    = ST_STOP;
              stb.emitStop = 1'b1;
            end
          end else begin
            bitCntNext   = bitCnt + 1'b1;
            stb.emitData = 1'b1;
          end
        end
        ST_MPB: begin
          stateNext    = ST_STOP;
          stb.emitStop = 1'b1;
        end
        ST_STOP: begin
          if (!tdre) begin
            stateNext     = ST_START;
            stb.emitStart = 1'b1;
            loadEvt       = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            endEvt    = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  // status flags and control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      tdre   <= 1'b1;
      tend   <= 1'b1;
      mpbt   <= 1'b0;
      txOn   <= 1'b0;
      mpMode <= 1'b0;
    end else begin
      if (stWr || dmaWrEn)      armed <= 1'b0;
      else if (stRd && tdre)    armed <= 1'b1;

      if (swClear || dmaWrEn)   tdre <= 1'b0;
      else if (loadEvt)         tdre <= 1'b1;

      if (!txOn)                tend <= 1'b1;
      else if (swClear || dmaWrEn) tend <= 1'b0;
      else if (endEvt)          tend <= 1'b1;

      if (stWr)   mpbt <= wrBits[STAT_MPB_BIT];
      if (ctrlWr) begin
        txOn   <= wrBits[0];
        mpMode <= wrBits[1];
      end
    end
  end

  p_tend_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txOn |=> tend);

  p_dma_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaWrEn && txOn) |=> (!tdre && !tend));

  p_load_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadEvt && !dmaWrEn && !swClear) |=> tdre);

  p_tend_ro_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !armed && !dmaWrEn && !baudTick && txOn) |=> $stable(tend));

  p_arm_needed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !armed && !dmaWrEn && !loadEvt) |=> $stable(tdre));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.emitStart, stb.emitData, stb.emitMpb, stb.emitStop, stb.forceIdle}));

endmodule

// File: rtl/async_tx_dp.sv
module async_tx_dp
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dmaWrEn,
  input  logic [DATA_W-1:0] dmaWrData,
  input  logic              tdre,
  input  logic              tend,
  input  logic              mpbt,
  input  logic              txOn,
  input  logic              mpMode,
  output logic [DATA_W-1:0] rdData,
  output logic              txLine
);

  logic [DATA_W-1:0] holdReg, shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (dmaWrEn) begin
      holdReg <= dmaWrData;
    end else if (wrEn && (addr == ADDR_W'(DATA_ADDR))) begin
      holdReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      txLine   <= 1'b1;
    end else begin
      if (stb.forceIdle) begin
        txLine <= 1'b1;
      end else if (stb.emitStart) begin
        txLine   <= 1'b0;
        shiftReg <= holdReg;
      end else if (stb.emitData) begin
        txLine   <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (stb.emitMpb) begin
        txLine <= mpbt;
      end else if (stb.emitStop) begin
        txLine <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rdData[0] = txOn;
      rdData[1] = mpMode;
    end else if (addr == ADDR_W'(DATA_ADDR)) begin
      rdData = holdReg;
    end else if (addr == ADDR_W'(STAT_ADDR)) begin
      rdData[STAT_MPB_BIT]  = mpbt;
      rdData[STAT_END_BIT]  = tend;
      rdData[STAT_TDRE_BIT] = tdre;
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitStart |=> !txLine);

  p_idle_line_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceIdle |=> txLine);

  p_stop_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitStop |=> txLine);

endmodule

// File: rtl/async_tx_flags.sv
module async_tx_flags
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              dmaWrEn,
  input  logic [DATA_W-1:0] dmaWrData,
  output logic              txLine
);

  txStrobe_t stb;
  logic tdre, tend, mpbt, txOn, mpMode;

  async_tx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .addr(busAddr), .wrEn(busWrEn), .rdEn(busRdEn),
    .wrBits(busWrData[2:0]), .dmaWrEn(dmaWrEn),
    .stb(stb), .tdre(tdre), .tend(tend), .mpbt(mpbt),
    .txOn(txOn), .mpMode(mpMode)
  );

  async_tx_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addr(busAddr), .wrEn(busWrEn), .wrData(busWrData),
    .dmaWrEn(dmaWrEn), .dmaWrData(dmaWrData),
    .tdre(tdre), .tend(tend), .mpbt(mpbt), .txOn(txOn), .mpMode(mpMode),
    .rdData(busRdData), .txLine(txLine)
  );

endmodule

// File: tb/async_tx_flags_bench.sv
`timescale 1ns/1ps
module async_tx_flags_bench;

  localparam int BAUD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0;
  logic [1:0] addr = 2'd2;
  logic wrEn = 1'b0, rdEn = 1'b0, dmaWrEn = 1'b0;
  logic [7:0] wrData = 8'h00, dmaData = 8'h00;
  logic [7:0] rdData;
  logic txLine;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  always #2 clk = ~clk;

  async_tx_flags u_async_tx_flags (
    .clk(clk), .rstN(rstN), .baudTick(baudTick),
    .busAddr(addr), .busWrEn(wrEn), .busRdEn(rdEn),
    .busWrData(wrData), .busRdData(rdData),
    .dmaWrEn(dmaWrEn), .dmaWrData(dmaData), .txLine(txLine)
  );

  // behavioural reference model
  bit mTdre, mTend, mArm, mOn, mMp, mMpbt, mLine, busy;
  bit ld, en, sw, sr, swc;
  logic [7:0] mData;
  int q[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mTdre = 1; mTend = 1; mArm = 0; mOn = 0; mMp = 0; mMpbt = 0;
      mLine = 1; busy = 0; mData = 8'h00; q.delete();
    end else begin
      sw  = wrEn && addr == 2'd2;
      sr  = rdEn && addr == 2'd2;
      swc = sw && !wrData[2] && mArm;
      ld = 0; en = 0;
      if (!mOn) begin
        busy = 0; q.delete(); mLine = 1;
      end else if (baudTick) begin
        if (!busy || q.size() == 0) begin
          if (!mTdre) begin
            q.delete();
            for (int i = 0; i < 8; i++) q.push_back(int'(mData[i]));
            if (mMp) q.push_back(2);
            q.push_back(1);
            mLine = 0; busy = 1; ld = 1;
          end else if (busy) begin
            busy = 0; en = 1;
          end
        end else begin
          int b;
          b = q.pop_front();
          mLine = (b == 2) ? mMpbt : b[0];
        end
      end
      if (sw || dmaWrEn) mArm = 0; else if (sr && mTdre) mArm = 1;
      if (swc || dmaWrEn) mTdre = 0; else if (ld) mTdre = 1;
      if (!mOn) mTend = 1; else if (swc || dmaWrEn) mTend = 0; else if (en) mTend = 1;
      if (sw) mMpbt = wrData[0];
      if (wrEn && addr == 2'd0) begin mOn = wrData[0]; mMp = wrData[1]; end
      if (dmaWrEn) mData = dmaData; else if (wrEn && addr == 2'd1) mData = wrData;
    end
  end

  function automatic logic [7:0] modelRd(input logic [1:0] a);
    case (a)
      2'd0: return {6'b0, mMp, mOn};
      2'd1: return mData;
      2'd2: return {5'b0, mTdre, mTend, mMpbt};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      chk({curTag, " line"}, {7'b0, txLine}, {7'b0, mLine});
      chk({curTag, " rd"}, rdData, modelRd(addr));
    end
  end

  initial begin
    forever begin
      for (int c = 0; c < BAUD; c++) begin
        @(negedge clk);
        baudTick = (c == BAUD - 1);
      end
    end
  end

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0; addr = 2'd2;
  endtask

  task automatic busRd(input logic [1:0] a);
    @(negedge clk); addr = a; rdEn = 1;
    @(negedge clk); rdEn = 0; addr = 2'd2;
  endtask

  task automatic dmaWr(input logic [7:0] d);
    @(negedge clk); dmaData = d; dmaWrEn = 1;
    @(negedge clk); dmaWrEn = 0;
  endtask

  task automatic waitTdre();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (rdData[2]) break;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    curTag = "R1";
    chk("R1 status", rdData, 8'h06);
    chk("R1 line", {7'b0, txLine}, 8'h01);
    addr = 2'd0; @(negedge clk); chk("R1 ctrl", rdData, 8'h00); addr = 2'd2;

    curTag = "R6";
    busWr(2'd0, 8'h01);
    busWr(2'd1, 8'hA5);
    busWr(2'd2, 8'h00);
    chk("R6 no-read write", rdData, 8'h06);
    busRd(2'd2);
    busWr(2'd2, 8'h00);
    chk("R6 armed clear", rdData, 8'h00);

    curTag = "R2";
    waitTdre();
    chk("R5 tdre after load", {7'b0, rdData[2]}, 8'h01);
    curTag = "R8";
    repeat (110) @(negedge clk);
    chk("R8 end flag", rdData, 8'h06);

    curTag = "R7";
    dmaWr(8'h3C);
    chk("R7 dma clear", rdData & 8'h06, 8'h00);
    addr = 2'd1; @(negedge clk); chk("R7 data", rdData, 8'h3C); addr = 2'd2;

    curTag = "R8";
    waitTdre();
    dmaWr(8'hC3);
    repeat (24) @(negedge clk);
    curTag = "R10";
    busWr(2'd2, 8'h02);
    chk("R10 ro end", rdData & 8'h06, 8'h00);
    curTag = "R8";
    waitTdre();
    repeat (110) @(negedge clk);
    chk("R8 end after pair", rdData & 8'h02, 8'h02);

    curTag = "R3";
    busWr(2'd0, 8'h03);
    busWr(2'd2, 8'h05);
    dmaWr(8'h0F);
    waitTdre();
    repeat (24) @(negedge clk);
    busWr(2'd2, 8'h04);
    repeat (110) @(negedge clk);
    busWr(2'd2, 8'h05);
    dmaWr(8'hF0);
    repeat (120) @(negedge clk);

    curTag = "R4";
    busWr(2'd0, 8'h01);
    dmaWr(8'h81);
    repeat (120) @(negedge clk);

    curTag = "R9";
    dmaWr(8'h55);
    waitTdre();
    repeat (30) @(negedge clk);
    busWr(2'd0, 8'h00);
    @(negedge clk);
    chk("R9 line high", {7'b0, txLine}, 8'h01);
    chk("R9 end high", rdData & 8'h02, 8'h02);
    curTag = "R11";
    repeat (40) @(negedge clk);
    chk("R11 idle line", {7'b0, txLine}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired R2 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule